// File: doc/BRIEF.md
# Width-Configurable Two-Clock Block Memory

This block is a 4096-bit memory with a write-only port and a read-only port. Each port has its own clock, clock enable and access enable. A 2-bit width code on each port chooses 16, 8, 4 or 2 data bits for that port, and each port chooses on its own. The storage is fixed at 256 rows of 16 bit columns. A narrow access reaches one interleaved subset of the columns in a row. Its data travels on fixed, scattered pins of the 16-bit data buses, not on the low pins.

The width codes are meant to stay static during normal use, although nothing prevents a change between accesses. Writing at one width and reading at another shows exactly how the lanes interleave. Each clock has a build-time option that moves its active edge to the falling edge. A single power input gates the whole memory, and its active level is also chosen at build time.

The block has no sequencing state machine. Its only states are "unpowered" and "powered", and the power input sets them directly with no transition logic. Every access is a single-edge event on its own port's clock.

Top module: `bram_sdp`

## Requirements
- R1: Bits [7:0] of an address select the row. In width code m (m = 0..3), address bits [7+m:8] select the column phase `sel`, and any higher address bits are ignored. In code 0 the bits [10:8] have no effect.
- R2: A write in code m with stride S = 2^m stores the data pin j*S+off into column j*S+sel, for j = 0 .. 16/S-1. The pin offset off is 0 for codes 0 and 1, 1 for code 2 and 3 for code 3. So the pins in use are all 16 (code 0), the even pins (code 1), pins 1, 5, 9 and 13 (code 2), and pins 3 and 11 (code 3).
- R3: A read in code m places column j*S+sel of the addressed row on pin j*S+off. Every pin outside that set reads as 0.
- R4: A write takes place only on an active write-clock edge where the write clock enable and the write enable are both 1.
- R5: In code 0, a write-mask bit of 1 keeps that column unchanged. In codes 1 to 3 the mask has no effect.
- R6: Read data is registered. It changes only on an active read-clock edge where the read clock enable and the read enable are both 1, and otherwise it holds its value.
- R7: While the power input is inactive, writes are dropped and read data is 0. The power input is active-low by default, and a parameter makes it active-high.
- R8: When a read and a write reach the same row on the same edge, the read returns the contents from before the write.
- R9: Each port has its own parameter that makes the falling edge of that port's clock the active edge.
- R10: The write width code and the read width code act independently, so any of the 16 pairings is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wce | input | 1 | Write clock enable |
| we | input | 1 | Write enable |
| waddr | input | 11 | Write address |
| wdata | input | 16 | Write data bus (lane pins depend on wmode) |
| wmask | input | 16 | Per-column write block, used in code 0 only |
| wmode | input | 2 | Write width code: 0=16, 1=8, 2=4, 3=2 bits |
| rclk | input | 1 | Read clock |
| rce | input | 1 | Read clock enable |
| re | input | 1 | Read enable |
| raddr | input | 11 | Read address |
| rmode | input | 2 | Read width code: 0=16, 1=8, 2=4, 3=2 bits |
| rdata | output | 16 | Registered read data bus |
| pwr_cfg | input | 1 | Power enable, polarity set by parameter |

## Verification
The hardest case to reach is a write at one width checked against a read at another width. Only that pairing shows whether the column phase and the pin offset are combined correctly. The bench zero-fills the memory, then runs every pairing of write code and read code with random data. The addresses come from only four rows but use all eight phase values, so narrow writes often land in columns that a wide read then exposes. Directed steps add the same-edge collision and a write issued while the memory is unpowered. A second instance, driven between clock edges, tests the falling-edge option.

// File: rtl/bram_sdp_pkg.sv
package bram_sdp_pkg;

    localparam int BUS_W  = 16;
    localparam int MODE_W = 2;

    typedef logic [MODE_W-1:0] wmode_t;

    // pin offset of lane 0 for each width code
    function automatic logic [3:0] lane_off(input wmode_t m);
        logic [3:0] o;
        unique case (m)
            2'd0:    o = 4'd0;
            2'd1:    o = 4'd0;
            2'd2:    o = 4'd1;
            default: o = 4'd3;
        endcase
        return o;
    endfunction

    // stride minus one: low column bits that form the phase
    function automatic logic [3:0] lane_msk(input wmode_t m);
        return 4'((1 << m) - 1);
    endfunction

    // set of data pins that carry data in width code m
    function automatic logic [BUS_W-1:0] pin_set(input wmode_t m);
        logic [BUS_W-1:0] s;
        s = '0;
        for (int p = 0; p < BUS_W; p++) begin
            if ((4'(p) & lane_msk(m)) == lane_off(m)) s[p] = 1'b1;
        end
        return s;
    endfunction

endpackage

// File: rtl/bram_wr_lanes.sv
module bram_wr_lanes
    import bram_sdp_pkg::*;
#(
    parameter int ADDR_W = 11,
    localparam int ROW_W = ADDR_W - 3
) (
    input  logic              clk,
    input  logic              pwr_ok,
    input  logic              wce,
    input  logic              we,
    input  wmode_t            mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [BUS_W-1:0]  wmask,
    output logic [ROW_W-1:0]  row,
    output logic [BUS_W-1:0]  col_en,
    output logic [BUS_W-1:0]  col_d
);

    logic       go;
    logic [3:0] msk;
    logic [3:0] off;
    logic [3:0] sel;
    logic [3:0] src;

    assign go  = pwr_ok && wce && we;
    assign msk = lane_msk(mode);
    assign off = lane_off(mode);
    assign sel = {1'b0, addr[ADDR_W-1:ROW_W]} & msk;
    assign row = addr[ROW_W-1:0];

    always_comb begin
        col_en = '0;
        col_d  = '0;
        src    = '0;
        for (int c = 0; c < BUS_W; c++) begin
            src       = (4'(c) & ~msk) + off;
            col_d[c]  = wdata[src];
            col_en[c] = go && ((4'(c) & msk) == sel)
                        && !((mode == 2'd0) && wmask[c]);
        end
    end

    // R2: a narrow write never touches more columns than its width
    p_lane_count_r2: assert property (@(posedge clk) disable iff (!pwr_ok)
        $countones(col_en) <= (BUS_W >> mode));

endmodule

// File: rtl/bram_rd_lanes.sv
module bram_rd_lanes
    import bram_sdp_pkg::*;
#(
    parameter int ADDR_W = 11,
    localparam int ROW_W = ADDR_W - 3
) (
    input  logic              clk,
    input  logic              pwr_ok,
    input  logic              rce,
    input  logic              re,
    input  wmode_t            mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  row_q,
    output logic [BUS_W-1:0]  rdata
);

    logic [3:0]       msk;
    logic [3:0]       off;
    logic [3:0]       sel;
    logic [3:0]       col;
    logic [BUS_W-1:0] nxt;
    logic             armed = 1'b0;

    assign msk = lane_msk(mode);
    assign off = lane_off(mode);
    assign sel = {1'b0, addr[ADDR_W-1:ROW_W]} & msk;

    always_comb begin
        nxt = '0;
        col = '0;
        for (int p = 0; p < BUS_W; p++) begin
            col = (4'(p) & ~msk) + sel;
            if ((4'(p) & msk) == off) nxt[p] = row_q[col];
        end
    end

    always_ff @(posedge clk) begin
        armed <= 1'b1;
        if (!pwr_ok)          rdata <= '0;
        else if (rce && re)   rdata <= nxt;
    end

    // R3: pins outside the read lane set stay zero after a read
    p_unused_zero_r3: assert property (@(posedge clk) disable iff (!pwr_ok)
        (rce && re) |=> ((rdata & ~pin_set($past(mode))) == '0));

    // R6: no enabled read, no change
    p_hold_r6: assert property (@(posedge clk) disable iff (!pwr_ok)
        !(rce && re) |=> $stable(rdata));

    // R7: unpowered read data is zero
    p_off_zero_r7: assert property (@(posedge clk) disable iff (!armed)
        !pwr_ok |=> (rdata == '0));

endmodule

// File: rtl/bram_sdp.sv
module bram_sdp
    import bram_sdp_pkg::*;
#(
    parameter int ADDR_W         = 11,
    parameter bit WCLK_INV       = 1'b0,
    parameter bit RCLK_INV       = 1'b0,
    parameter bit PWR_ACTIVE_LOW = 1'b1,
    localparam int ROW_W = ADDR_W - 3,
    localparam int ROWS  = 1 << ROW_W
) (
    input  logic              wclk,
    input  logic              wce,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [BUS_W-1:0]  wmask,
    input  logic [1:0]        wmode,
    input  logic              rclk,
    input  logic              rce,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    input  logic [1:0]        rmode,
    output logic [BUS_W-1:0]  rdata,
    input  logic              pwr_cfg
);

    logic             wclk_i;
    logic             rclk_i;
    logic             pwr_ok;
    logic [ROW_W-1:0] wrow;
    logic [BUS_W-1:0] col_en;
    logic [BUS_W-1:0] col_d;
    logic [BUS_W-1:0] rd_row;
    logic [BUS_W-1:0] mem [ROWS];

    generate
        if (WCLK_INV) begin : g_wclk_neg
            assign wclk_i = ~wclk;
        end else begin : g_wclk_pos
            assign wclk_i = wclk;
        end
        if (RCLK_INV) begin : g_rclk_neg
            assign rclk_i = ~rclk;
        end else begin : g_rclk_pos
            assign rclk_i = rclk;
        end
        if (PWR_ACTIVE_LOW) begin : g_pwr_low
            assign pwr_ok = ~pwr_cfg;
        end else begin : g_pwr_high
            assign pwr_ok = pwr_cfg;
        end
    endgenerate

    bram_wr_lanes #(.ADDR_W(ADDR_W)) u_wr (
        .clk    (wclk_i),
        .pwr_ok (pwr_ok),
        .wce    (wce),
        .we     (we),
        .mode   (wmode),
        .addr   (waddr),
        .wdata  (wdata),
        .wmask  (wmask),
        .row    (wrow),
        .col_en (col_en),
        .col_d  (col_d)
    );

    always_ff @(posedge wclk_i) begin
        for (int c = 0; c < BUS_W; c++) begin
            if (col_en[c]) mem[wrow][c] <= col_d[c];
        end
    end

    assign rd_row = mem[raddr[ROW_W-1:0]];

    bram_rd_lanes #(.ADDR_W(ADDR_W)) u_rd (
        .clk    (rclk_i),
        .pwr_ok (pwr_ok),
        .rce    (rce),
        .re     (re),
        .mode   (rmode),
        .addr   (raddr),
        .row_q  (rd_row),
        .rdata  (rdata)
    );

endmodule

// File: tb/bram_sdp_bench.sv
`timescale 1ns/100ps
module bram_sdp_bench;

    logic        clk = 1'b0;
    logic        wce = 0, we = 0, rce = 0, re = 0, pwr_cfg = 1'b1;
    logic [10:0] waddr = '0, raddr = '0;
    logic [15:0] wdata = '0, wmask = '0, rdata;
    logic [1:0]  wmode = '0, rmode = '0;

    logic        i_we = 0, i_re = 0, i_pwr = 0;
    logic [10:0] i_addr = '0;
    logic [15:0] i_wdata = '0, i_rdata;

    int checks = 0, fails = 0;
    bit done = 0;
    bit pwr_on = 0;
    logic [15:0] refm [256];
    logic [15:0] exp_q = '0;

    always #2.5 clk = ~clk;

    bram_sdp u_bram_sdp (
        .wclk(clk), .wce(wce), .we(we), .waddr(waddr), .wdata(wdata),
        .wmask(wmask), .wmode(wmode), .rclk(clk), .rce(rce), .re(re),
        .raddr(raddr), .rmode(rmode), .rdata(rdata), .pwr_cfg(pwr_cfg)
    );

    bram_sdp #(.WCLK_INV(1'b1), .RCLK_INV(1'b1), .PWR_ACTIVE_LOW(1'b0)) u_bram_sdp_inv (
        .wclk(clk), .wce(1'b1), .we(i_we), .waddr(i_addr), .wdata(i_wdata),
        .wmask(16'h0000), .wmode(2'd0), .rclk(clk), .rce(1'b1), .re(i_re),
        .raddr(i_addr), .rmode(2'd0), .rdata(i_rdata), .pwr_cfg(i_pwr)
    );

    function automatic int offs(input bit [1:0] m);
        return (m == 2) ? 1 : (m == 3) ? 3 : 0;
    endfunction

    function automatic logic [15:0] model_rd(input bit [1:0] m, input bit [10:0] a);
        int s = 1 << m;
        int sel = (a >> 8) & (s - 1);
        logic [15:0] r = '0;
        for (int j = 0; j < 16 / s; j++) r[j*s + offs(m)] = refm[a[7:0]][j*s + sel];
        return r;
    endfunction

    function automatic void model_wr(input bit [1:0] m, input bit [10:0] a,
                                     input bit [15:0] d, input bit [15:0] k);
        int s = 1 << m;
        int sel = (a >> 8) & (s - 1);
        for (int j = 0; j < 16 / s; j++)
            if (!(m == 0 && k[j])) refm[a[7:0]][j*s + sel] = d[j*s + offs(m)];
    endfunction

    task automatic check(input logic [15:0] act, input logic [15:0] expv, input string tag);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // called at a falling edge; one full clock per step
    task automatic step(input bit wen, input bit wcev, input bit [1:0] wm, input bit [10:0] wa,
                        input bit [15:0] wd, input bit [15:0] wk,
                        input bit ren, input bit rcev, input bit [1:0] rm, input bit [10:0] ra,
                        input bit chk, input string tag);
        if (!pwr_on)            exp_q = '0;
        else if (ren && rcev)   exp_q = model_rd(rm, ra);
        if (pwr_on && wen && wcev) model_wr(wm, wa, wd, wk);
        we = wen; wce = wcev; wmode = wm; waddr = wa; wdata = wd; wmask = wk;
        re = ren; rce = rcev; rmode = rm; raddr = ra;
        @(posedge clk);
        @(negedge clk);
        we = 0; re = 0;
        if (chk) check(rdata, exp_q, tag);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog run did not complete");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        // reset state: unpowered, reads enabled -> zero (R7)
        @(negedge clk);
        step(0, 1, 0, 0, 0, 0, 1, 1, 0, 0, 1, "R7 unpowered reset read");
        // power on and zero-fill
        pwr_cfg = 1'b0; pwr_on = 1;
        for (int r = 0; r < 256; r++) step(1, 1, 0, 11'(r), 0, 0, 0, 0, 0, 0, 0, "fill");
        // write while unpowered is dropped (R7)
        pwr_cfg = 1'b1; pwr_on = 0;
        step(1, 1, 0, 11'd5, 16'hFFFF, 0, 1, 1, 0, 11'd5, 1, "R7 read while unpowered");
        pwr_cfg = 1'b0; pwr_on = 1;
        step(0, 1, 0, 0, 0, 0, 1, 1, 0, 11'd5, 1, "R7 write dropped while unpowered");
        // enables gate writes (R4)
        step(1, 0, 0, 11'd6, 16'hA5A5, 0, 0, 0, 0, 0, 0, "");
        step(0, 1, 0, 11'd6, 16'hA5A5, 0, 1, 1, 0, 11'd6, 1, "R4 no write without both enables");
        // mask in code 0, ignored in code 1 (R5)
        step(1, 1, 0, 11'd7, 16'hFFFF, 16'h00FF, 0, 0, 0, 0, 0, "");
        step(0, 1, 0, 0, 0, 0, 1, 1, 0, 11'd7, 1, "R5 mask blocks columns");
        step(1, 1, 1, 11'd8, 16'h5555, 16'hFFFF, 0, 0, 0, 0, 0, "");
        step(0, 1, 0, 0, 0, 0, 1, 1, 0, 11'd8, 1, "R5 mask ignored in code 1");
        // high address bits ignored in code 0 (R1)
        step(1, 1, 0, 11'h709, 16'h1234, 0, 0, 0, 0, 0, 0, "");
        step(0, 1, 0, 0, 0, 0, 1, 1, 0, 11'h009, 1, "R1 code 0 ignores high address bits");
        // cross width: 2-bit write, 16-bit read (R2 R3)
        step(1, 1, 3, 11'h50A, 16'h0808, 0, 0, 0, 0, 0, 0, "");
        step(0, 1, 0, 0, 0, 0, 1, 1, 0, 11'h00A, 1, "R2 code 3 lanes seen at full width");
        step(0, 1, 0, 0, 0, 0, 1, 1, 3, 11'h50A, 1, "R3 code 3 read lanes");
        // hold without read enable (R6)
        step(1, 1, 0, 11'h00A, 16'hFFFF, 0, 1, 0, 0, 11'h00A, 1, "R6 hold when read clock enable low");
        // collision returns old contents (R8)
        step(1, 1, 0, 11'h00B, 16'hBEEF, 0, 1, 1, 0, 11'h00B, 1, "R8 old data on same-edge read");
        step(0, 1, 0, 0, 0, 0, 1, 1, 0, 11'h00B, 1, "R8 new data after collision");
        // random across all width pairings (R10 R2 R3 R1 R6)
        for (int wm = 0; wm < 4; wm++) begin
            for (int rm = 0; rm < 4; rm++) begin
                for (int n = 0; n < 40; n++) begin
                    bit [10:0] wa = {3'($urandom), 6'd0, 2'($urandom)};
                    bit [10:0] ra = {3'($urandom), 6'd0, 2'($urandom)};
                    bit [15:0] wk = ($urandom % 4 == 0) ? 16'($urandom) : 16'h0;
                    step($urandom % 4 != 0, $urandom % 8 != 0, 2'(wm), wa, 16'($urandom), wk,
                         $urandom % 4 != 0, $urandom % 8 != 0, 2'(rm), ra, 1,
                         "R10 R2 R3 R6 random pairing");
                end
            end
        end
        // falling-edge option on second instance (R9)
        @(negedge clk); #0.5;
        i_pwr = 1'b1; i_addr = 11'd3; i_wdata = 16'hC3A5; i_we = 1;
        @(negedge clk); #0.5;
        i_we = 0; i_re = 1;
        @(posedge clk); #0.5;
        check(i_rdata, 16'h0000, "R9 no capture on rising edge");
        @(negedge clk); #0.5;
        i_re = 0;
        check(i_rdata, 16'hC3A5, "R9 capture on falling edge");
        @(negedge clk);
        finish_run();
    end

endmodule